// File: doc/BRIEF.md
# Chained Double-Buffered DMA Channel

This block holds the register set and the word sequencer of a single DMA channel. Software programs a start address and a word count into a staging pair of registers. It then writes the control word with the enable bit set. The channel issues one word request at a time toward a memory master, and every acknowledge moves it one word forward. Software may stage the following transfer while the present one is still running. When the last word is acknowledged, the staged address and count move into the live registers on the same clock edge, and requests continue with no idle cycle.

Addresses are word aligned. Each address is split into a 1 MB page field (bits 31..20) and a word offset field (bits 19..2). The count field sits in bits 19..2 and counts 32-bit words. When a transfer finishes, the channel can raise an interrupt flag, which software clears by writing the control word. Status outputs give the live address and the remaining count on every cycle.

Top module: `dma_chain_channel`

## Requirements
- R1: After reset, all four registers read zero, `memReq` is low and `irq` is low.
- R2: The register at word select 1 (staged address) reads back with bits 1..0 as zero. The register at select 3 (control) holds enable in bit 29, interrupt enable in bit 27, direction in bit 25, burst in bit 24 and the staged count in bits 19..2. Bit 31 of select 3 reads the interrupt flag, and every other bit reads zero. Writes to select 0 (live address) and select 2 (live count, bits 19..2) have no effect.
- R3: A control write with bit 29 set marks the staged transfer valid. If the channel is idle (live count zero), the staged address and count load into the live registers on the next clock edge.
- R4: Each cycle in which `memReq` and `memAck` are both high adds 4 to the live address and subtracts 1 from the live count. The offset wraps inside the 1 MB page, and the page bits never change.
- R5: When the last word is acknowledged while a staged transfer is valid, the staged values load on that same edge, the valid mark clears, and `memReq` stays high with no gap.
- R6: When the last word is acknowledged and nothing is staged, the channel goes idle. The live count is zero, the live address is one word past the final word, and `memReq` is low.
- R7: Each completion (last-word acknowledge) sets the interrupt flag if interrupt enable is set, and leaves it unchanged if not. Any control write clears the flag, but a completion in the same cycle takes priority and sets it.
- R8: `memReq` is high only while enable is set and the live count is nonzero. A control write with bit 29 clear pauses the channel with its address and count held, and cancels any staged transfer.
- R9: `memRead` follows control bit 25, and `memBurst` follows control bit 24.
- R10: `memAddr` and `liveAddr` equal the live address register, and `liveCount` equals the live count register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe |
| busSel | input | 2 | Register word select (0 live address, 1 staged address, 2 live count, 3 control) |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Read data of the selected register (combinational) |
| memReq | output | 1 | Word request toward the memory master |
| memAddr | output | 32 | Address of the requested word |
| memRead | output | 1 | 1 means the word is read from memory |
| memBurst | output | 1 | Burst enable toward the memory master |
| memAck | input | 1 | Word acknowledge |
| irq | output | 1 | End-of-transfer interrupt |
| liveAddr | output | 32 | Live address status |
| liveCount | output | 32 | Remaining count status (words in bits 19..2) |

## Verification
Several rules are checked on every cycle. The single-word step must advance the address inside its page and lower the count by one. Requests must never appear with a zero count. The live count may not move without an acknowledge. The interrupt flag must clear on a control write and hold between events. Other behaviour can only be seen in the bench scenarios: the gapless hand-over into a staged transfer, its exact timing relative to the control write, the ignored writes to the read-only registers, the pause and cancel on clearing enable, and a completion beating a clearing write in the same cycle.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int ADDR_W = 32;
  localparam int OFF_W  = 18;
  localparam int CNT_W  = OFF_W;
  localparam int PAGE_W = ADDR_W - OFF_W - 2;

  localparam int IRQ_BIT   = 31;
  localparam int EN_BIT    = 29;
  localparam int IE_BIT    = 27;
  localparam int DIR_BIT   = 25;
  localparam int BURST_BIT = 24;

  localparam logic [1:0] SEL_LIVE_ADDR  = 2'd0;
  localparam logic [1:0] SEL_NEXT_ADDR  = 2'd1;
  localparam logic [1:0] SEL_LIVE_COUNT = 2'd2;
  localparam logic [1:0] SEL_CTRL       = 2'd3;

  typedef struct packed {
    logic loadNextAddr;
    logic loadNextCount;
    logic advance;
    logic handover;
  } dmaStrobe_t;
endpackage

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
  import dma_chain_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWr,
  input  logic [1:0] busSel,
  input  logic       wrEn,
  input  logic       wrIe,
  input  logic       wrDir,
  input  logic       wrBurst,
  input  logic       memAck,
  input  logic       countZero,
  input  logic       lastWord,
  output dmaStrobe_t strb,
  output logic       memReq,
  output logic       ctrlEn,
  output logic       ctrlIe,
  output logic       ctrlDir,
  output logic       ctrlBurst,
  output logic       irqFlag
);
  logic nextValid;
  logic ctrlWr;
  logic done;

  assign ctrlWr = busWr && (busSel == SEL_CTRL);
  assign memReq = ctrlEn && !countZero;
  assign done   = strb.advance && lastWord;

  always_comb begin
    strb.loadNextAddr  = busWr && (busSel == SEL_NEXT_ADDR);
    strb.loadNextCount = ctrlWr;
    strb.advance       = memReq && memAck;
    strb.handover      = nextValid && (done || countZero);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlEn    <= 1'b0;
      ctrlIe    <= 1'b0;
      ctrlDir   <= 1'b0;
      ctrlBurst <= 1'b0;
      nextValid <= 1'b0;
    end else if (ctrlWr) begin
      ctrlEn    <= wrEn;
      ctrlIe    <= wrIe;
      ctrlDir   <= wrDir;
      ctrlBurst <= wrBurst;
      nextValid <= wrEn;
    end else if (strb.handover) begin
      nextValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqFlag <= 1'b0;
    else if (done && ctrlIe) irqFlag <= 1'b1;
    else if (ctrlWr) irqFlag <= 1'b0;
  end
endmodule

// File: rtl/dma_chain_datapath.sv
module dma_chain_datapath
  import dma_chain_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int OW = OFF_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  dmaStrobe_t    strb,
  input  logic [AW-3:0] wrAddr,
  input  logic [CW-1:0] wrCount,
  output logic [AW-1:0] curAddr,
  output logic [AW-1:0] nextAddr,
  output logic [CW-1:0] curCount,
  output logic [CW-1:0] nextCount,
  output logic          countZero,
  output logic          lastWord
);
  localparam int PW = AW - OW - 2;

  logic [PW-1:0]  curPage;
  logic [OW-1:0]  curOff;
  logic [AW-3:0]  nextWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPage  <= '0;
      curOff   <= '0;
      curCount <= '0;
    end else if (strb.handover) begin
      {curPage, curOff} <= nextWord;
      curCount          <= nextCount;
    end else if (strb.advance) begin
      curOff   <= curOff + 1'b1;
      curCount <= curCount - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextWord  <= '0;
      nextCount <= '0;
    end else begin
      if (strb.loadNextAddr)  nextWord  <= wrAddr;
      if (strb.loadNextCount) nextCount <= wrCount;
    end
  end

  assign curAddr   = {curPage, curOff, 2'b00};
  assign nextAddr  = {nextWord, 2'b00};
  assign countZero = (curCount == '0);
  assign lastWord  = (curCount == CW'(1));
endmodule

// File: rtl/dma_chain_channel.sv
module dma_chain_channel
  import dma_chain_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic [1:0]  busSel,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  output logic        memReq,
  output logic [31:0] memAddr,
  output logic        memRead,
  output logic        memBurst,
  input  logic        memAck,
  output logic        irq,
  output logic [31:0] liveAddr,
  output logic [31:0] liveCount
);
  dmaStrobe_t       strb;
  logic [31:0]      curAddr, nextAddr;
  logic [CNT_W-1:0] curCount, nextCount;
  logic             countZero, lastWord;
  logic             ctrlEn, ctrlIe, ctrlDir, ctrlBurst, irqFlag;
  logic [31:0]      ctrlWord, countWord;
  logic             unusedWrBits;

  assign unusedWrBits = ^{busWrData[1:0], busWrData[31:30], busWrData[28],
                          busWrData[26], busWrData[23:20]};

  dma_chain_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busSel(busSel),
    .wrEn(busWrData[EN_BIT]), .wrIe(busWrData[IE_BIT]),
    .wrDir(busWrData[DIR_BIT]), .wrBurst(busWrData[BURST_BIT]),
    .memAck(memAck), .countZero(countZero), .lastWord(lastWord),
    .strb(strb), .memReq(memReq), .ctrlEn(ctrlEn), .ctrlIe(ctrlIe),
    .ctrlDir(ctrlDir), .ctrlBurst(ctrlBurst), .irqFlag(irqFlag)
  );

  dma_chain_datapath uData (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrAddr(busWrData[31:2]), .wrCount(busWrData[CNT_W+1:2]),
    .curAddr(curAddr), .nextAddr(nextAddr), .curCount(curCount),
    .nextCount(nextCount), .countZero(countZero), .lastWord(lastWord)
  );

  always_comb begin
    ctrlWord            = '0;
    ctrlWord[IRQ_BIT]   = irqFlag;
    ctrlWord[EN_BIT]    = ctrlEn;
    ctrlWord[IE_BIT]    = ctrlIe;
    ctrlWord[DIR_BIT]   = ctrlDir;
    ctrlWord[BURST_BIT] = ctrlBurst;
    ctrlWord[CNT_W+1:2] = nextCount;
    countWord           = '0;
    countWord[CNT_W+1:2] = curCount;
  end

  always_comb begin
    unique case (busSel)
      SEL_LIVE_ADDR:  busRdData = curAddr;
      SEL_NEXT_ADDR:  busRdData = nextAddr;
      SEL_LIVE_COUNT: busRdData = countWord;
      default:        busRdData = ctrlWord;
    endcase
  end

  assign memAddr   = curAddr;
  assign memRead   = ctrlDir;
  assign memBurst  = ctrlBurst;
  assign irq       = irqFlag;
  assign liveAddr  = curAddr;
  assign liveCount = countWord;
endmodule

// File: rtl/dma_chain_checker.sv
module dma_chain_checker (
  input logic        clk,
  input logic        rstN,
  input logic        busWr,
  input logic [1:0]  busSel,
  input logic        memReq,
  input logic        memAck,
  input logic        irq,
  input logic [31:0] liveAddr,
  input logic [31:0] liveCount
);
  logic lastAck, ctrlWrite;
  assign lastAck   = memReq && memAck && (liveCount[19:2] == 18'd1);
  assign ctrlWrite = busWr && (busSel == 2'd3);

  a_r8_no_req_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    (liveCount == 32'd0) |-> !memReq);

  a_r4_word_step: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck && liveCount[19:2] > 18'd1) |=>
      (liveAddr[19:0] == $past(liveAddr[19:0]) + 20'd4) &&
      (liveAddr[31:20] == $past(liveAddr[31:20])) &&
      (liveCount[19:2] == $past(liveCount[19:2]) - 18'd1));

  a_r7_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrite && !lastAck) |=> !irq);

  a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlWrite && !lastAck) |=> (irq == $past(irq)));

  a_r4_count_needs_ack: assert property (@(posedge clk) disable iff (!rstN)
    (!(memReq && memAck) && liveCount != 32'd0) |=> (liveCount == $past(liveCount)));
endmodule

bind dma_chain_channel dma_chain_checker uChk (.*);

// File: tb/dma_chain_channel_test.sv
`timescale 1ns/1ps
module dma_chain_channel_test;
  logic        clk = 1'b0;
  logic        rstN, busWr, memAck;
  logic [1:0]  busSel;
  logic [31:0] busWrData, busRdData, memAddr, liveAddr, liveCount;
  logic        memReq, memRead, memBurst, irq;

  always #2 clk = ~clk;

  dma_chain_channel uut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busSel(busSel),
    .busWrData(busWrData), .busRdData(busRdData), .memReq(memReq),
    .memAddr(memAddr), .memRead(memRead), .memBurst(memBurst),
    .memAck(memAck), .irq(irq), .liveAddr(liveAddr), .liveCount(liveCount)
  );

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  logic [31:0] mAddr, mNext;
  logic [17:0] mCount, mNextCount;
  logic        mNv, mEn, mIe, mDir, mBurst, mIrq;

  function automatic logic [31:0] mRead(input logic [1:0] s);
    logic [31:0] v;
    v = '0;
    case (s)
      2'd0: v = mAddr;
      2'd1: v = mNext;
      2'd2: v[19:2] = mCount;
      default: begin
        v[31] = mIrq; v[29] = mEn; v[27] = mIe; v[25] = mDir; v[24] = mBurst;
        v[19:2] = mNextCount;
      end
    endcase
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic modelEdge(input logic wr, input logic [1:0] sel,
                           input logic [31:0] d, input logic ack);
    logic req, adv, done, ho, cw;
    req  = mEn && (mCount != 0);
    adv  = req && ack;
    done = adv && (mCount == 18'd1);
    ho   = mNv && (done || mCount == 0);
    cw   = wr && (sel == 2'd3);
    if (ho) begin
      mAddr = mNext; mCount = mNextCount;
    end else if (adv) begin
      mAddr = {mAddr[31:20], mAddr[19:0] + 20'd4}; mCount = mCount - 18'd1;
    end
    if (done && mIe) mIrq = 1'b1;
    else if (cw) mIrq = 1'b0;
    if (cw) begin
      mEn = d[29]; mIe = d[27]; mDir = d[25]; mBurst = d[24];
      mNv = d[29]; mNextCount = d[19:2];
    end else if (ho) mNv = 1'b0;
    if (wr && sel == 2'd1) mNext = {d[31:2], 2'b00};
  endtask

  task automatic compareAll();
    logic [1:0] rs;
    check("R10 liveAddr", liveAddr, mAddr);
    check("R10 memAddr", memAddr, mAddr);
    check("R4 liveCount", liveCount, {12'd0, mCount, 2'b00});
    check("R8 memReq", {31'd0, memReq}, {31'd0, mEn && mCount != 0});
    check("R7 irq", {31'd0, irq}, {31'd0, mIrq});
    check("R9 memRead/memBurst", {30'd0, memRead, memBurst}, {30'd0, mDir, mBurst});
    rs = 2'($urandom % 4);
    busSel = rs;
    #1;
    check("R2 register read", busRdData, mRead(rs));
  endtask

  task automatic cyc(input logic wr, input logic [1:0] sel,
                     input logic [31:0] d, input logic ack);
    busWr = wr; busSel = sel; busWrData = d; memAck = ack;
    @(posedge clk);
    modelEdge(wr, sel, d, ack);
    @(negedge clk);
    busWr = 1'b0;
    compareAll();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    rstN = 1'b0; busWr = 1'b0; busSel = 2'd0; busWrData = '0; memAck = 1'b0;
    mAddr = '0; mNext = '0; mCount = '0; mNextCount = '0;
    mNv = 0; mEn = 0; mIe = 0; mDir = 0; mBurst = 0; mIrq = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int s = 0; s < 4; s++) begin
      busSel = 2'(s); #1;
      check("R1 reset read", busRdData, 32'd0);
    end
    check("R1 reset memReq/irq", {30'd0, memReq, irq}, 32'd0);

    // R2: writes to the read-only registers are ignored
    cyc(1'b1, 2'd0, 32'hFFFF_FFFF, 1'b0);
    cyc(1'b1, 2'd2, 32'hFFFF_FFFF, 1'b0);
    check("R2 live address write ignored", liveAddr, 32'd0);
    check("R2 live count write ignored", liveCount, 32'd0);

    // R3 + R4 page wrap: staged 0x123FFFF8, 3 words, interrupt on
    cyc(1'b1, 2'd1, 32'h123F_FFFB, 1'b0);
    d = 32'h2A00_0000 | (32'd3 << 2);
    cyc(1'b1, 2'd3, d, 1'b0);
    check("R3 no request right after start write", {31'd0, memReq}, 32'd0);
    cyc(1'b0, 2'd0, 32'd0, 1'b0);
    check("R3 staged address loaded", liveAddr, 32'h123F_FFF8);
    check("R3 request after load", {31'd0, memReq}, 32'd1);
    // stage a chained transfer of 2 words during the run
    cyc(1'b1, 2'd1, 32'h0000_0100, 1'b1);
    cyc(1'b1, 2'd3, 32'h2800_0000 | (32'd2 << 2), 1'b1);
    check("R4 offset wraps inside page", liveAddr, 32'h1230_0000);
    cyc(1'b0, 2'd0, 32'd0, 1'b1);
    check("R5 chained address loaded without gap", liveAddr, 32'h0000_0100);
    check("R5 request stays high", {31'd0, memReq}, 32'd1);
    check("R7 flag set on completion", {31'd0, irq}, 32'd1);
    cyc(1'b0, 2'd0, 32'd0, 1'b1);
    cyc(1'b0, 2'd0, 32'd0, 1'b1);
    check("R6 idle address one past final word", liveAddr, 32'h0000_0108);
    check("R6 idle count zero", liveCount, 32'd0);

    // R8: pause by clearing enable
    cyc(1'b1, 2'd1, 32'h0004_0000, 1'b0);
    cyc(1'b1, 2'd3, 32'h2000_0000 | (32'd4 << 2), 1'b0);
    cyc(1'b0, 2'd0, 32'd0, 1'b1);
    cyc(1'b1, 2'd3, 32'h0000_0000, 1'b1);
    cyc(1'b0, 2'd0, 32'd0, 1'b1);
    check("R8 paused count held", liveCount, 32'd3 << 2);
    check("R8 paused no request", {31'd0, memReq}, 32'd0);

    // randomized traffic
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic ack;
      r = int'($urandom % 100);
      ack = ($urandom % 100) < 70;
      if (r < 6) begin
        d = $urandom;
        if ($urandom % 3 == 0) d[19:0] = 20'hFFFF0 | 20'($urandom % 16);
        cyc(1'b1, 2'd1, d, ack);
      end else if (r < 12) begin
        d = $urandom;
        d[29] = ($urandom % 100) < 85;
        d[19:2] = 18'($urandom % 6);
        cyc(1'b1, 2'd3, d, ack);
      end else if (r < 14) begin
        cyc(1'b1, ($urandom % 2) ? 2'd0 : 2'd2, $urandom, ack);
      end else begin
        cyc(1'b0, 2'd0, 32'd0, ack);
      end
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule